// File: doc/BRIEF.md
# Eight-Stage Pipeline Hazard Controller

This block decides, cycle by cycle, whether the front of an in-order scalar integer pipeline may advance. The pipeline has eight stages: two fetch stages, decode with register read, execute, two data-cache stages, tag check and writeback. The controller looks at the decoded fields of the instruction sitting in decode. It also keeps its own record of the loads and branches it has already let into execute and beyond. From these it produces three signals. The first holds the two fetch stages and decode. The second turns the execute-stage input into a bubble. The third kills a delay-slot instruction as it leaves decode.

A load's result can be used only two cycles later than a plain ALU result. A consumer directly behind a load therefore waits two cycles, and a consumer two places behind waits one. A branch resolves in execute. The instruction behind it (the delay slot) always issues, and two stall cycles follow it. For the likely form of a branch, the delay slot is annulled when the branch falls through. A freeze input from the cache-miss logic stops everything and overrides every other cause. The datapath, the caches and the miss handling live outside this block.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: Reset clears all tracked loads and branches. A consumer of a register loaded just before reset does not stall after reset.
- R2: A valid decode instruction whose enabled source field (A or B) names the destination of the load issued one cycle earlier stalls for exactly two cycles. Each of those cycles has front_stall_o=1 and ex_bubble_o=1. The instruction then issues.
- R3: A consumer that is two issue slots behind a load stalls for exactly one cycle.
- R4: A load whose destination is register 0 never causes a stall. A source field whose enable bit is 0 never causes a stall, whatever register it names.
- R5: After a branch issues, its delay slot issues in the next free cycle. Exactly two cycles of front_stall_o=1 with ex_bubble_o=1 follow. This holds whether or not the branch is taken.
- R6: For a likely branch that is not taken (ex_br_taken_i=0 while the branch is in execute), slot_annul_o=1 in the cycle its delay slot leaves decode. front_stall_o=0 in that cycle.
- R7: A taken likely branch, and any ordinary branch, leaves its delay slot un-annulled.
- R8: The branch outcome is sampled only while the branch is in execute. If a load hazard holds the delay slot in decode, the captured outcome decides the annul. Later values of ex_br_taken_i are ignored.
- R9: While freeze_i=1: front_stall_o=1, ex_bubble_o=0 and slot_annul_o=0, and no tracked state advances. Pending load and branch stalls resume unchanged afterwards.
- R10: ex_bubble_o=1 exactly when the block itself stalls decode. It is never 1 while freeze_i=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| freeze_i | input | 1 | Whole-pipeline hold from tag-check miss logic |
| dec_valid_i | input | 1 | Decode stage holds a real instruction |
| dec_src_a_i | input | 5 | First source register number |
| dec_src_a_en_i | input | 1 | First source is read |
| dec_src_b_i | input | 5 | Second source register number |
| dec_src_b_en_i | input | 1 | Second source is read |
| dec_dst_i | input | 5 | Destination register of a load in decode |
| dec_is_load_i | input | 1 | Decode instruction is a load |
| dec_is_branch_i | input | 1 | Decode instruction is a branch |
| dec_is_likely_i | input | 1 | The branch in decode is the likely form |
| ex_br_taken_i | input | 1 | Outcome of the branch now in execute |
| front_stall_o | output | 1 | Hold fetch stages and decode |
| ex_bubble_o | output | 1 | Insert a bubble into execute |
| slot_annul_o | output | 1 | Turn the delay slot leaving decode into a bubble |

## Verification
The bench targets these corner cases:
- A consumer one slot and one two slots behind a load. A design that counts the load latency wrong stalls one cycle too many or too few.
- Reads of register 0 and disabled source fields. Without gating, these would stall without cause.
- A freeze during a load stall and a freeze during a branch stall. A design that lets its counters run under freeze loses the remaining stall cycles, and one that ignores freeze priority emits a bubble or an annul during the hold.
- A likely-branch delay slot held by a load hazard. A design that reads the outcome late, once the branch has left execute, makes the wrong annul decision.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int unsigned REG_W = 5;

  typedef logic [REG_W-1:0] reg_id_t;

  typedef struct packed {
    logic    live;
    reg_id_t dst;
  } ld_slot_t;
endpackage

// File: rtl/hz_rst_sync.sv
module hz_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_q_n <= meta_q;
    end
  end
endmodule

// File: rtl/hz_load_track.sv
// Records loads that left decode, one slot per cycle of use latency,
// and flags a decode source that matches any of them.
module hz_load_track
  import hz_pkg::*;
#(
  parameter int unsigned GAP = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    adv,
  input  logic    push,
  input  reg_id_t push_dst,
  input  reg_id_t src_a,
  input  logic    src_a_en,
  input  reg_id_t src_b,
  input  logic    src_b_en,
  output logic    hit
);
  ld_slot_t [GAP-1:0] chain_q;
  ld_slot_t [GAP-1:0] chain_d;
  logic     [GAP-1:0] slot_hit;

  always_comb begin
    chain_d[0] = '{live: push, dst: push_dst};
    for (int i = 1; i < GAP; i++) begin
      chain_d[i] = chain_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else if (adv) begin
      chain_q <= chain_d;
    end
  end

  for (genvar g = 0; g < GAP; g++) begin : g_cmp
    logic nonzero;
    assign nonzero     = (chain_q[g].dst != '0);
    assign slot_hit[g] = chain_q[g].live && nonzero &&
                         ((src_a_en && (src_a == chain_q[g].dst)) ||
                          (src_b_en && (src_b == chain_q[g].dst)));
  end

  assign hit = |slot_hit;
endmodule

// File: rtl/hz_branch_seq.sv
// Tracks a branch from decode through execute, decides the delay-slot
// annul and counts the post-slot stall cycles.
module hz_branch_seq #(
  parameter int unsigned BR_STALLS = 2,
  localparam int unsigned CNT_W = $clog2(BR_STALLS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic freeze,
  input  logic dec_valid,
  input  logic ld_hz,
  input  logic dec_br,
  input  logic dec_lk,
  input  logic ex_taken,
  output logic busy,
  output logic issue,
  output logic annul
);
  logic             ex_br_q, ex_br_d;
  logic             ex_lk_q, ex_lk_d;
  logic             wait_q, wait_d;
  logic             kill_q, kill_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             kill_now;
  logic             slot_go;

  assign busy     = (cnt_q != '0);
  assign issue    = dec_valid && !freeze && !ld_hz && !busy;
  assign kill_now = ex_br_q && ex_lk_q && !ex_taken;
  assign slot_go  = issue && wait_q;
  assign annul    = slot_go && (kill_q || kill_now);

  always_comb begin
    ex_br_d = issue && dec_br;
    ex_lk_d = issue && dec_lk;
    wait_d  = issue ? dec_br : wait_q;
    if (slot_go)       kill_d = 1'b0;
    else if (kill_now) kill_d = 1'b1;
    else               kill_d = kill_q;
    if (slot_go)       cnt_d = CNT_W'(BR_STALLS);
    else if (busy)     cnt_d = cnt_q - CNT_W'(1);
    else               cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_br_q <= 1'b0;
      ex_lk_q <= 1'b0;
      wait_q  <= 1'b0;
      kill_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (!freeze) begin
      ex_br_q <= ex_br_d;
      ex_lk_q <= ex_lk_d;
      wait_q  <= wait_d;
      kill_q  <= kill_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import hz_pkg::*;
#(
  parameter int unsigned LOAD_GAP  = 2,
  parameter int unsigned BR_STALLS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             freeze_i,
  input  logic             dec_valid_i,
  input  logic [REG_W-1:0] dec_src_a_i,
  input  logic             dec_src_a_en_i,
  input  logic [REG_W-1:0] dec_src_b_i,
  input  logic             dec_src_b_en_i,
  input  logic [REG_W-1:0] dec_dst_i,
  input  logic             dec_is_load_i,
  input  logic             dec_is_branch_i,
  input  logic             dec_is_likely_i,
  input  logic             ex_br_taken_i,
  output logic             front_stall_o,
  output logic             ex_bubble_o,
  output logic             slot_annul_o
);
  logic rst_q_n;
  logic ld_hit, ld_hz;
  logic br_busy, issue, annul;
  logic ld_push;
  logic stall_raw;

  hz_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  hz_load_track #(.GAP(LOAD_GAP)) u_ld (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .adv      (!freeze_i),
    .push     (ld_push),
    .push_dst (dec_dst_i),
    .src_a    (dec_src_a_i),
    .src_a_en (dec_src_a_en_i),
    .src_b    (dec_src_b_i),
    .src_b_en (dec_src_b_en_i),
    .hit      (ld_hit)
  );

  hz_branch_seq #(.BR_STALLS(BR_STALLS)) u_br (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .freeze    (freeze_i),
    .dec_valid (dec_valid_i),
    .ld_hz     (ld_hz),
    .dec_br    (dec_is_branch_i),
    .dec_lk    (dec_is_likely_i),
    .ex_taken  (ex_br_taken_i),
    .busy      (br_busy),
    .issue     (issue),
    .annul     (annul)
  );

  // An annulled slot enters execute as a bubble, so its load is not tracked.
  assign ld_hz     = dec_valid_i && ld_hit;
  assign ld_push   = issue && dec_is_load_i && !annul;
  assign stall_raw = br_busy || ld_hz;

  assign front_stall_o = freeze_i || stall_raw;
  assign ex_bubble_o   = !freeze_i && stall_raw;
  assign slot_annul_o  = annul;
endmodule

// File: rtl/hz_ctrl_chk.sv
module hz_ctrl_chk
  import hz_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             freeze_i,
  input logic             dec_valid_i,
  input logic [REG_W-1:0] dec_src_a_i,
  input logic             dec_src_a_en_i,
  input logic [REG_W-1:0] dec_src_b_i,
  input logic             dec_src_b_en_i,
  input logic [REG_W-1:0] dec_dst_i,
  input logic             dec_is_load_i,
  input logic             front_stall_o,
  input logic             ex_bubble_o,
  input logic             slot_annul_o
);
  logic    live_q;
  logic    pend_v_q;
  reg_id_t pend_d_q;
  logic    ld_left;
  logic    uses_pend;

  assign ld_left = dec_valid_i && dec_is_load_i && !front_stall_o &&
                   !slot_annul_o && (dec_dst_i != '0);
  assign uses_pend = (dec_src_a_en_i && (dec_src_a_i == pend_d_q)) ||
                     (dec_src_b_en_i && (dec_src_b_i == pend_d_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q   <= 1'b0;
      pend_v_q <= 1'b0;
      pend_d_q <= '0;
    end else begin
      live_q <= 1'b1;
      if (!freeze_i) begin
        pend_v_q <= ld_left;
        pend_d_q <= dec_dst_i;
      end
    end
  end

  assert_freeze_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_i |-> (front_stall_o && !ex_bubble_o && !slot_annul_o));

  assert_bubble_tracks_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !freeze_i |-> (ex_bubble_o == front_stall_o));

  assert_load_use_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && pend_v_q && !freeze_i && dec_valid_i && uses_pend) |-> front_stall_o);

  assert_annul_on_issue_R6: assert property (@(posedge clk) disable iff (!rst_n)
    slot_annul_o |-> (dec_valid_i && !front_stall_o));

  assert_stall_after_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(slot_annul_o) && !$past(freeze_i) && !freeze_i) |-> front_stall_o);
endmodule

bind pipe_hazard_ctrl hz_ctrl_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_q_n),
  .freeze_i       (freeze_i),
  .dec_valid_i    (dec_valid_i),
  .dec_src_a_i    (dec_src_a_i),
  .dec_src_a_en_i (dec_src_a_en_i),
  .dec_src_b_i    (dec_src_b_i),
  .dec_src_b_en_i (dec_src_b_en_i),
  .dec_dst_i      (dec_dst_i),
  .dec_is_load_i  (dec_is_load_i),
  .front_stall_o  (front_stall_o),
  .ex_bubble_o    (ex_bubble_o),
  .slot_annul_o   (slot_annul_o)
);

// File: tb/pipe_hazard_ctrl_tb.sv
`timescale 1ns/1ps
module pipe_hazard_ctrl_tb;
  typedef struct packed {
    logic [3:0] req;
    logic       v;
    logic [4:0] a;
    logic       ae;
    logic [4:0] b;
    logic       be;
    logic [4:0] d;
    logic       ld, br, lk, tk, fz;
    logic       es, eb, ea;
  } vec_t;

  function automatic vec_t mk(input int r, input logic v, input int a, input logic ae,
                              input int b, input logic be, input int d,
                              input logic ld, input logic br, input logic lk,
                              input logic tk, input logic fz,
                              input logic es, input logic eb, input logic ea);
    vec_t t;
    t.req = 4'(r); t.v = v; t.a = 5'(a); t.ae = ae; t.b = 5'(b); t.be = be;
    t.d = 5'(d); t.ld = ld; t.br = br; t.lk = lk; t.tk = tk; t.fz = fz;
    t.es = es; t.eb = eb; t.ea = ea;
    return t;
  endfunction

  localparam int NV = 56;
  localparam vec_t TBL [NV] = '{
    mk(1, 0, 0,0, 0,0, 0, 0,0,0,0,0, 0,0,0),  // R1 idle after reset
    mk(2, 1, 1,1, 0,0, 5, 1,0,0,0,0, 0,0,0),  // R2 load r5
    mk(2, 1, 5,1, 0,0, 0, 0,0,0,0,0, 1,1,0),  // R2 R10 use r5, stall 1
    mk(2, 1, 5,1, 0,0, 0, 0,0,0,0,0, 1,1,0),  // R2 stall 2
    mk(2, 1, 5,1, 0,0, 0, 0,0,0,0,0, 0,0,0),  // R2 issues
    mk(3, 1, 1,1, 0,0, 7, 1,0,0,0,0, 0,0,0),  // R3 load r7
    mk(3, 1, 2,1, 0,0, 0, 0,0,0,0,0, 0,0,0),  // R3 independent
    mk(3, 1, 0,0, 7,1, 0, 0,0,0,0,0, 1,1,0),  // R3 use r7 via B, one stall
    mk(3, 1, 0,0, 7,1, 0, 0,0,0,0,0, 0,0,0),
    mk(4, 1, 1,1, 0,0, 0, 1,0,0,0,0, 0,0,0),  // R4 load r0
    mk(4, 1, 0,1, 0,0, 0, 0,0,0,0,0, 0,0,0),  // R4 read r0: no stall
    mk(4, 1, 1,1, 0,0, 3, 1,0,0,0,0, 0,0,0),  // R4 load r3
    mk(4, 1, 3,0, 4,1, 0, 0,0,0,0,0, 0,0,0),  // R4 r3 named but disabled
    mk(5, 1, 9,1, 0,0, 0, 0,1,0,0,0, 0,0,0),  // R5 branch
    mk(7, 1,10,1, 0,0, 0, 0,0,0,1,0, 0,0,0),  // R7 R5 slot, ordinary taken
    mk(5, 1,11,1, 0,0, 0, 0,0,0,0,0, 1,1,0),
    mk(5, 1,11,1, 0,0, 0, 0,0,0,0,0, 1,1,0),
    mk(5, 1,11,1, 0,0, 0, 0,0,0,0,0, 0,0,0),
    mk(6, 1, 9,1, 0,0, 0, 0,1,1,0,0, 0,0,0),  // R6 likely branch
    mk(6, 1,10,1, 0,0, 0, 0,0,0,0,0, 0,0,1),  // R6 not taken: annul
    mk(5, 1,11,1, 0,0, 0, 0,0,0,0,0, 1,1,0),  // R5 not-taken still stalls
    mk(5, 1,11,1, 0,0, 0, 0,0,0,0,0, 1,1,0),
    mk(5, 1,11,1, 0,0, 0, 0,0,0,0,0, 0,0,0),
    mk(7, 1, 9,1, 0,0, 0, 0,1,1,0,0, 0,0,0),  // R7 likely branch
    mk(7, 1,10,1, 0,0, 0, 0,0,0,1,0, 0,0,0),  // R7 taken: slot kept
    mk(5, 1,11,1, 0,0, 0, 0,0,0,0,0, 1,1,0),
    mk(5, 1,11,1, 0,0, 0, 0,0,0,0,0, 1,1,0),
    mk(5, 1,11,1, 0,0, 0, 0,0,0,0,0, 0,0,0),
    mk(9, 1, 1,1, 0,0, 8, 1,0,0,0,0, 0,0,0),  // R9 load r8
    mk(9, 1, 8,1, 0,0, 0, 0,0,0,0,1, 1,0,0),  // R9 freeze over hazard
    mk(9, 1, 8,1, 0,0, 0, 0,0,0,0,0, 1,1,0),  // R9 both stalls remain
    mk(9, 1, 8,1, 0,0, 0, 0,0,0,0,0, 1,1,0),
    mk(9, 1, 8,1, 0,0, 0, 0,0,0,0,0, 0,0,0),
    mk(9, 1, 9,1, 0,0, 0, 0,1,0,0,0, 0,0,0),  // R9 branch
    mk(9, 1,10,1, 0,0, 0, 0,0,0,1,0, 0,0,0),
    mk(9, 1,11,1, 0,0, 0, 0,0,0,0,0, 1,1,0),
    mk(9, 1,11,1, 0,0, 0, 0,0,0,0,1, 1,0,0),  // R9 freeze in branch stall
    mk(9, 1,11,1, 0,0, 0, 0,0,0,0,0, 1,1,0),
    mk(9, 1,11,1, 0,0, 0, 0,0,0,0,0, 0,0,0),
    mk(9, 1, 9,1, 0,0, 0, 0,1,1,0,0, 0,0,0),  // R9 likely branch
    mk(9, 1,10,1, 0,0, 0, 0,0,0,0,1, 1,0,0),  // R9 freeze blocks annul
    mk(6, 1,10,1, 0,0, 0, 0,0,0,0,0, 0,0,1),  // R6 annul after freeze
    mk(5, 1,11,1, 0,0, 0, 0,0,0,0,0, 1,1,0),
    mk(5, 1,11,1, 0,0, 0, 0,0,0,0,0, 1,1,0),
    mk(5, 1,11,1, 0,0, 0, 0,0,0,0,0, 0,0,0),
    mk(2, 1, 1,1, 0,0,12, 1,0,0,0,0, 0,0,0),  // R2 load r12
    mk(2, 1, 1,1,12,1, 0, 0,0,0,0,0, 1,1,0),  // R2 use via B
    mk(2, 1, 1,1,12,1, 0, 0,0,0,0,0, 1,1,0),
    mk(2, 1, 1,1,12,1, 0, 0,0,0,0,0, 0,0,0),
    mk(8, 1, 1,1, 0,0,13, 1,0,0,0,0, 0,0,0),  // R8 load r13
    mk(8, 1, 1,1, 0,0, 0, 0,1,1,0,0, 0,0,0),  // R8 likely branch
    mk(8, 1,13,1, 0,0, 0, 0,0,0,0,0, 1,1,0),  // R8 slot held, not taken seen
    mk(8, 1,13,1, 0,0, 0, 0,0,0,1,0, 0,0,1),  // R8 late taken ignored
    mk(8, 1,11,1, 0,0, 0, 0,0,0,0,0, 1,1,0),
    mk(8, 1,11,1, 0,0, 0, 0,0,0,0,0, 1,1,0),
    mk(8, 1,11,1, 0,0, 0, 0,0,0,0,0, 0,0,0)
  };

  logic       clk, rst_n, freeze_i, dec_valid_i;
  logic [4:0] dec_src_a_i, dec_src_b_i, dec_dst_i;
  logic       dec_src_a_en_i, dec_src_b_en_i;
  logic       dec_is_load_i, dec_is_branch_i, dec_is_likely_i, ex_br_taken_i;
  logic       front_stall_o, ex_bubble_o, slot_annul_o;
  int         checks = 0;
  int         fails  = 0;
  logic       done   = 1'b0;

  pipe_hazard_ctrl u_dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic drive(input vec_t t);
    dec_valid_i = t.v; dec_src_a_i = t.a; dec_src_a_en_i = t.ae;
    dec_src_b_i = t.b; dec_src_b_en_i = t.be; dec_dst_i = t.d;
    dec_is_load_i = t.ld; dec_is_branch_i = t.br; dec_is_likely_i = t.lk;
    ex_br_taken_i = t.tk; freeze_i = t.fz;
  endtask

  task automatic check(input string tag, input logic es, input logic eb, input logic ea);
    checks++;
    if ({front_stall_o, ex_bubble_o, slot_annul_o} !== {es, eb, ea}) begin
      fails++;
      $display("FAIL %s stall/bubble/annul actual=%b%b%b expected=%b%b%b",
               tag, front_stall_o, ex_bubble_o, slot_annul_o, es, eb, ea);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(mk(0, 0,0,0,0,0,0, 0,0,0,0,0, 0,0,0));
    repeat (2) @(negedge clk);
    #2 check("R1", 0, 0, 0);               // reset state
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TBL[i]);
      #2 check($sformatf("R%0d", TBL[i].req), TBL[i].es, TBL[i].eb, TBL[i].ea);
    end

    // R1: a load tracked before reset is forgotten
    @(negedge clk);
    drive(mk(0, 1,1,1,0,0,4, 1,0,0,0,0, 0,0,0));
    @(negedge clk);
    rst_n = 1'b0;
    drive(mk(0, 1,4,1,0,0,0, 0,0,0,0,0, 0,0,0));
    #2 check("R1", 0, 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(mk(0, 0,0,0,0,0,0, 0,0,0,0,0, 0,0,0));
    repeat (4) @(negedge clk);
    drive(mk(0, 1,4,1,0,0,0, 0,0,0,0,0, 0,0,0));
    #2 check("R1", 0, 0, 0);

    // R10: a self-caused stall bubbles execute; freeze alone does not
    @(negedge clk);
    drive(mk(0, 1,1,1,0,0,6, 1,0,0,0,0, 0,0,0));
    @(negedge clk);
    drive(mk(0, 1,6,1,0,0,0, 0,0,0,0,0, 0,0,0));
    #2 check("R10", 1, 1, 0);
    @(negedge clk);
    drive(mk(0, 1,6,1,0,0,0, 0,0,0,0,1, 0,0,0));
    #2 check("R10", 1, 0, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule